// File: doc/BRIEF.md
# Streaming Room Reverberator Datapath

This block adds room ambience to one audio channel. Each accepted input sample passes through an eight-tap early-reflection filter. It then goes through a bank of four parallel feedback combs whose outputs are summed, two all-pass diffusers in series and a one-pole low-pass stage that softens the tail. The result is added to the dry sample and the early reflections. One reverberated sample comes back for every sample taken in, exactly one clock later.

Room presets are applied by writing delays and gains through a small register-write port. All samples and coefficients are signed Q1.23 (24 bits). Every stage sums in a wider accumulator and clamps its result back to 24 bits, so no stage ever wraps around.

Top module: `reverb_core`

## Requirements
- R1: Samples and coefficients are signed Q1.23. A product c*v is floor(c*v / 2^23). Every stage result is clamped to the range -8388608..8388607, so a sum beyond full scale gives 0x7FFFFF or 0x800000 and never wraps.
- R2: Every cycle with in_valid high gives out_valid high in the following cycle with the result on out_sample. In a cycle after one without in_valid, out_valid is low and out_sample keeps its value.
- R3: The early-reflection stage computes e[n] = clamp(sum over k = 0..7 of g_k * x[n-d_k]). Each tap delay is 0..2047, and a delay of 0 uses the current input.
- R4: Each of the four combs keeps a line b[n] = clamp(e[n] + g*y[n]) and outputs y[n] = b[n-D], which gives y[n] = e[n-D] + g*y[n-D]. The comb sum is the clamped sum of the four outputs.
- R5: Two all-pass stages in series each compute y[n] = clamp(x[n-D] + g*y[n-D] - g*x[n]). The first stage takes the comb sum as its input.
- R6: The low-pass stage computes y[n] = clamp(s + a*(x[n] - s)), where s is its previous output and the difference is taken at full width.
- R7: out_sample = clamp(x[n] + e[n] + low-pass output).
- R8: A write sets the entry selected by cfg_addr[5:3] (group) and cfg_addr[2:0] (index). The groups are: 0 tap delay, 1 tap gain, 2 comb delay, 3 comb gain, 4 all-pass delay, 5 all-pass gain, 6 low-pass coefficient (index 0 only). Group 7, comb indices 4..7, all-pass indices 2..7 and low-pass indices 1..7 are ignored.
- R9: Delays take the low bits of cfg_wdata: 11 bits for taps, 8 bits for combs and 7 bits for all-pass stages. A comb or all-pass delay that comes out as 0 is stored as 1.
- R10: A write in the same cycle as an accepted sample does not affect that sample; it applies from the next sample on.
- R11: After reset all gains, the low-pass coefficient and all tap delays are 0, comb and all-pass delays are 1, and all delay lines hold zero. The output therefore equals the input, and out_valid and out_sample are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Dry input sample, Q1.23 |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_addr | input | 6 | Parameter group and index |
| cfg_wdata | input | 24 | Parameter value |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Reverberated sample, Q1.23 |

## Verification
The assertions assume that parameter writes and samples come only while reset is released. They also assume that in_valid is a level sampled each clock, and that a gain of -1.0 (0x800000) is never loaded. The all-pass pure-delay check further assumes that a zero gain really removes the feedback term. The stimulus writes only gains strictly inside ±1 and keeps every programmed delay within its line. Samples arrive back-to-back or with explicit idle gaps, and stay well below the bench's wrap-safe history length.

// File: rtl/rvb_pkg.sv
`timescale 1ns/1ps
package rvb_pkg;
  parameter int SMP_W = 24;
  parameter int ACC_W = 32;
  parameter int FRAC  = SMP_W - 1;

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  // widen a sample with sign extension
  function automatic acc_t wide(smp_t s);
    return acc_t'(s);
  endfunction

  // clamp a wide sum back into sample range
  function automatic smp_t sat(acc_t v);
    acc_t hi;
    acc_t lo;
    hi = (acc_t'(1) <<< FRAC) - acc_t'(1);
    lo = -(acc_t'(1) <<< FRAC);
    if (v > hi) return smp_t'(hi);
    if (v < lo) return smp_t'(lo);
    return smp_t'(v);
  endfunction

  // Q1.23 coefficient times wide value, floor rounding
  function automatic acc_t mulq(smp_t c, acc_t v);
    logic signed [SMP_W+ACC_W-1:0] p;
    p = c * v;
    return acc_t'(p >>> FRAC);
  endfunction
endpackage

// File: rtl/rvb_fir.sv
`timescale 1ns/1ps
module rvb_fir import rvb_pkg::*; #(
  parameter int NTAP  = 8,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  smp_t          x_in,
  input  logic [AW-1:0] tap_dly [NTAP],
  input  smp_t          tap_gain [NTAP],
  output smp_t          y_out
);
  smp_t          hist [DEPTH];
  logic [AW-1:0] wp;
  smp_t          tap_val [NTAP];
  acc_t          acc;

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap_val[k] = (tap_dly[k] == '0) ? x_in : hist[wp - tap_dly[k]];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) acc = acc + mulq(tap_gain[k], wide(tap_val[k]));
  end
  assign y_out = sat(acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (en) begin
      hist[wp] <= x_in;
      wp       <= wp + AW'(1);
    end
  end

  // R3
  fir_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> wp == $past(wp) + AW'(1));
endmodule

// File: rtl/rvb_comb.sv
`timescale 1ns/1ps
module rvb_comb import rvb_pkg::*; #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  smp_t          x_in,
  input  logic [AW-1:0] dly,
  input  smp_t          gain,
  output smp_t          y_out
);
  smp_t          line [DEPTH];
  logic [AW-1:0] wp;
  smp_t          fb;

  assign y_out = line[wp - dly];
  assign fb    = sat(wide(x_in) + mulq(gain, wide(y_out)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
    end else if (en) begin
      line[wp] <= fb;
      wp       <= wp + AW'(1);
    end
  end

  // R4
  comb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(wp));
endmodule

// File: rtl/rvb_allpass.sv
`timescale 1ns/1ps
module rvb_allpass import rvb_pkg::*; #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  smp_t          x_in,
  input  logic [AW-1:0] dly,
  input  smp_t          gain,
  output smp_t          y_out
);
  smp_t          xl [DEPTH];
  smp_t          yl [DEPTH];
  logic [AW-1:0] wp;
  smp_t          xd;
  smp_t          yd;

  assign xd    = xl[wp - dly];
  assign yd    = yl[wp - dly];
  assign y_out = sat(wide(xd) + mulq(gain, wide(yd)) - mulq(gain, wide(x_in)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        xl[i] <= '0;
        yl[i] <= '0;
      end
    end else if (en) begin
      xl[wp] <= x_in;
      yl[wp] <= y_out;
      wp     <= wp + AW'(1);
    end
  end

  // R5
  ap_pure_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gain == '0) |-> y_out == xd);
endmodule

// File: rtl/rvb_lowpass.sv
`timescale 1ns/1ps
module rvb_lowpass import rvb_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  smp_t x_in,
  input  smp_t coef,
  output smp_t y_out
);
  smp_t st;

  assign y_out = sat(wide(st) + mulq(coef, wide(x_in) - wide(st)));

  always_ff @(posedge clk) begin
    if (!rst_n)  st <= '0;
    else if (en) st <= y_out;
  end

  // R6
  lp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && coef == '0) |=> st == $past(st));
endmodule

// File: rtl/reverb_core.sv
`timescale 1ns/1ps
module reverb_core import rvb_pkg::*; #(
  parameter int NTAP       = 8,
  parameter int NCOMB      = 4,
  parameter int NAP        = 2,
  parameter int FIR_DEPTH  = 2048,
  parameter int COMB_DEPTH = 256,
  parameter int AP_DEPTH   = 128,
  localparam int FIR_AW    = $clog2(FIR_DEPTH),
  localparam int CMB_AW    = $clog2(COMB_DEPTH),
  localparam int AP_AW     = $clog2(AP_DEPTH),
  localparam int TAP_IW    = $clog2(NTAP),
  localparam int CMB_IW    = $clog2(NCOMB),
  localparam int AP_IW     = $clog2(NAP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_sample,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_addr,
  input  logic [SMP_W-1:0] cfg_wdata,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_sample
);
  localparam logic [2:0] GRP_TDLY = 3'd0;
  localparam logic [2:0] GRP_TGN  = 3'd1;
  localparam logic [2:0] GRP_CDLY = 3'd2;
  localparam logic [2:0] GRP_CGN  = 3'd3;
  localparam logic [2:0] GRP_ADLY = 3'd4;
  localparam logic [2:0] GRP_AGN  = 3'd5;
  localparam logic [2:0] GRP_LPA  = 3'd6;

  logic [FIR_AW-1:0] tap_d [NTAP];
  smp_t              tap_g [NTAP];
  logic [CMB_AW-1:0] cmb_d [NCOMB];
  smp_t              cmb_g [NCOMB];
  logic [AP_AW-1:0]  ap_d  [NAP];
  smp_t              ap_g  [NAP];
  smp_t              lp_a;

  logic       sample_take;
  logic [2:0] grp;
  logic [2:0] idx;
  smp_t       x_s, fir_y, csum, lp_y, mix;
  smp_t       comb_y [NCOMB];
  smp_t       ap_io  [NAP+1];
  acc_t       csum_acc;

  assign sample_take = in_valid;
  assign grp = cfg_addr[5:3];
  assign idx = cfg_addr[2:0];
  assign x_s = smp_t'(in_sample);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP; k++)  begin tap_d[k] <= '0; tap_g[k] <= '0; end
      for (int c = 0; c < NCOMB; c++) begin cmb_d[c] <= CMB_AW'(1); cmb_g[c] <= '0; end
      for (int a = 0; a < NAP; a++)   begin ap_d[a] <= AP_AW'(1); ap_g[a] <= '0; end
      lp_a <= '0;
    end else if (cfg_we) begin
      case (grp)
        GRP_TDLY: if (int'(idx) < NTAP) tap_d[idx[TAP_IW-1:0]] <= cfg_wdata[FIR_AW-1:0];
        GRP_TGN:  if (int'(idx) < NTAP) tap_g[idx[TAP_IW-1:0]] <= smp_t'(cfg_wdata);
        GRP_CDLY: if (int'(idx) < NCOMB)
          cmb_d[idx[CMB_IW-1:0]] <= (cfg_wdata[CMB_AW-1:0] == '0) ? CMB_AW'(1) : cfg_wdata[CMB_AW-1:0];
        GRP_CGN:  if (int'(idx) < NCOMB) cmb_g[idx[CMB_IW-1:0]] <= smp_t'(cfg_wdata);
        GRP_ADLY: if (int'(idx) < NAP)
          ap_d[idx[AP_IW-1:0]] <= (cfg_wdata[AP_AW-1:0] == '0) ? AP_AW'(1) : cfg_wdata[AP_AW-1:0];
        GRP_AGN:  if (int'(idx) < NAP) ap_g[idx[AP_IW-1:0]] <= smp_t'(cfg_wdata);
        GRP_LPA:  if (idx == 3'd0) lp_a <= smp_t'(cfg_wdata);
        default: ;
      endcase
    end
  end

  rvb_fir #(.NTAP(NTAP), .DEPTH(FIR_DEPTH)) u_fir (
    .clk(clk), .rst_n(rst_n), .en(sample_take), .x_in(x_s),
    .tap_dly(tap_d), .tap_gain(tap_g), .y_out(fir_y));

  for (genvar c = 0; c < NCOMB; c++) begin : g_comb
    rvb_comb #(.DEPTH(COMB_DEPTH)) u_comb (
      .clk(clk), .rst_n(rst_n), .en(sample_take), .x_in(fir_y),
      .dly(cmb_d[c]), .gain(cmb_g[c]), .y_out(comb_y[c]));
  end

  always_comb begin
    csum_acc = '0;
    for (int c = 0; c < NCOMB; c++) csum_acc = csum_acc + wide(comb_y[c]);
  end
  assign csum     = sat(csum_acc);
  assign ap_io[0] = csum;

  for (genvar a = 0; a < NAP; a++) begin : g_ap
    rvb_allpass #(.DEPTH(AP_DEPTH)) u_ap (
      .clk(clk), .rst_n(rst_n), .en(sample_take), .x_in(ap_io[a]),
      .dly(ap_d[a]), .gain(ap_g[a]), .y_out(ap_io[a+1]));
  end

  rvb_lowpass u_lp (
    .clk(clk), .rst_n(rst_n), .en(sample_take), .x_in(ap_io[NAP]),
    .coef(lp_a), .y_out(lp_y));

  assign mix = sat(wide(x_s) + wide(fir_y) + wide(lp_y));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= sample_take;
      if (sample_take) out_sample <= mix;
    end
  end

  // R2
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sample)));
endmodule

// File: tb/reverb_core_tb.sv
`timescale 1ns/1ps
module reverb_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_sample = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic        out_valid;
  logic [23:0] out_sample;

  int errors = 0;
  int checks = 0;

  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic [23:0] last_exp = '0;

  // bench-side parameter mirror
  longint m_td [8], m_tg [8], m_cd [4], m_cg [4], m_ad [2], m_ag [2];
  longint m_lp;
  // history rows: 0 input, 1 early refl, 2..5 comb lines, 6..7 ap in, 8..9 ap out
  longint hv [10][2048];
  longint lp_s = 0;
  int     n = 0;

  reverb_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_sample(out_sample));

  always #2 clk = ~clk;

  function automatic longint clampv(longint v);
    if (v > 64'sd8388607)  return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic longint qmul(longint c, longint v);
    return (c * v) >>> 23;
  endfunction

  function automatic longint rd(int row, int i);
    if (i < 0) return 0;
    return hv[row][i % 2048];
  endfunction

  function automatic longint sv(logic [23:0] d);
    return longint'($signed(d));
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(bit ok, string tag, logic [23:0] act, logic [23:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic mirror_reset();
    for (int k = 0; k < 8; k++) begin m_td[k] = 0; m_tg[k] = 0; end
    for (int c = 0; c < 4; c++) begin m_cd[c] = 1; m_cg[c] = 0; end
    for (int a = 0; a < 2; a++) begin m_ad[a] = 1; m_ag[a] = 0; end
    m_lp = 0;
    for (int r = 0; r < 10; r++) for (int i = 0; i < 2048; i++) hv[r][i] = 0;
  endtask

  // R8 R9 mirror of the write rules
  task automatic mirror_write(logic [5:0] a, logic [23:0] d);
    int g = int'(a[5:3]);
    int i = int'(a[2:0]);
    case (g)
      0: m_td[i] = longint'(d[10:0]);
      1: m_tg[i] = sv(d);
      2: if (i < 4) m_cd[i] = (d[7:0] == 0) ? 1 : longint'(d[7:0]);
      3: if (i < 4) m_cg[i] = sv(d);
      4: if (i < 2) m_ad[i] = (d[6:0] == 0) ? 1 : longint'(d[6:0]);
      5: if (i < 2) m_ag[i] = sv(d);
      6: if (i == 0) m_lp = sv(d);
      default: ;
    endcase
  endtask

  // reference model of one sample, pushes the expected output
  task automatic model(logic [23:0] x, string tag);
    longint xs, e, s, z, y, o;
    xs = sv(x);
    hv[0][n % 2048] = xs;
    e = 0;
    for (int k = 0; k < 8; k++)
      e += qmul(m_tg[k], (m_td[k] == 0) ? xs : rd(0, n - int'(m_td[k])));
    e = clampv(e);
    hv[1][n % 2048] = e;
    s = 0;
    for (int c = 0; c < 4; c++) begin
      y = rd(2 + c, n - int'(m_cd[c]));
      hv[2 + c][n % 2048] = clampv(e + qmul(m_cg[c], y));
      s += y;
    end
    z = clampv(s);
    for (int a = 0; a < 2; a++) begin
      y = clampv(rd(6 + a, n - int'(m_ad[a])) + qmul(m_ag[a], rd(8 + a, n - int'(m_ad[a])))
                 - qmul(m_ag[a], z));
      hv[6 + a][n % 2048] = z;
      hv[8 + a][n % 2048] = y;
      z = y;
    end
    lp_s = clampv(lp_s + qmul(m_lp, z - lp_s));
    o = clampv(xs + e + lp_s);
    exp_q.push_back(o[23:0]);
    tag_q.push_back(tag);
    n++;
  endtask

  task automatic send(logic [23:0] x, string tag);
    in_valid  = 1'b1;
    in_sample = x;
    model(x, tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_w(logic [23:0] x, logic [5:0] a, logic [23:0] d, string tag);
    in_valid = 1'b1; in_sample = x;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    model(x, tag);
    mirror_write(a, d);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [23:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    mirror_write(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic impulse(logic [23:0] amp, int tail, string tag);
    send(amp, tag);
    for (int i = 0; i < tail; i++) send(24'h0, tag);
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected out_valid act=%h exp=none", out_sample);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        check(out_sample === e, t, out_sample, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2: watchdog expired act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    mirror_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(out_valid === 1'b0, "R11", {23'b0, out_valid}, 24'h0);
    check(out_sample === 24'h0, "R11", out_sample, 24'h0);
    // R11 dry passthrough with defaults
    send(24'h123456, "R11"); send(24'h7FFFFF, "R11");
    send(24'h800000, "R11"); send(24'hFFFFFF, "R11");
    // R2 gaps: idle cycles hold the output
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R2", {23'b0, out_valid}, 24'h0);
    check(out_sample === last_exp, "R2", out_sample, last_exp);
    send(24'h000100, "R2"); @(negedge clk); send(24'hFFF000, "R2");
    // R3 early reflections, incl. delay 0 and 2047
    wr(6'o00, 24'd0);    wr(6'o10, 24'h200000);
    wr(6'o01, 24'd3);    wr(6'o11, 24'h400000);
    wr(6'o07, 24'd2047); wr(6'o17, 24'hC00000);
    impulse(24'h100000, 12, "R3");
    for (int i = 0; i < 2040; i++) send(24'h0, "R3");
    // R4 combs, low-pass wide open
    wr(6'o60, 24'h7FFFFF);
    wr(6'o20, 24'd5);  wr(6'o30, 24'h400000);
    wr(6'o21, 24'd7);  wr(6'o31, 24'h300000);
    wr(6'o22, 24'd11); wr(6'o32, 24'hC00000);
    wr(6'o23, 24'd13); wr(6'o33, 24'h200000);
    impulse(24'h080000, 60, "R4");
    // R5 all-pass diffusers
    wr(6'o40, 24'd3); wr(6'o50, 24'h500000);
    wr(6'o41, 24'd4); wr(6'o51, 24'hB00000);
    impulse(24'h080000, 50, "R5");
    // R6 low-pass smoothing
    wr(6'o60, 24'h200000);
    impulse(24'h200000, 30, "R6");
    // R7 mix of dry, early and tail with a varied input
    for (int i = 0; i < 20; i++) send(24'(i * 24'h031000 - 24'h200000), "R7");
    // R9 delay clamping and truncation
    wr(6'o20, 24'd0); wr(6'o40, 24'd300);
    impulse(24'h100000, 50, "R9");
    // R8 writes to absent entries are ignored
    wr(6'o35, 24'h7FFFFF); wr(6'o72, 24'h7FFFFF);
    wr(6'o62, 24'h7FFFFF); wr(6'o53, 24'h7FFFFF);
    impulse(24'h100000, 20, "R8");
    // R10 write in the same cycle as a sample
    send_w(24'h300000, 6'o60, 24'h000000, "R10");
    for (int i = 0; i < 5; i++) send(24'h100000, "R10");
    // R1 saturation at both rails
    wr(6'o10, 24'h7FFFFF);
    for (int i = 0; i < 4; i++) send(24'h700000, "R1");
    for (int i = 0; i < 4; i++) send(24'h900000, "R1");
    repeat (4) @(negedge clk);
    // R2 every input produced exactly one output
    check(exp_q.size() == 0, "R2", 24'(exp_q.size()), 24'h0);
    summary();
    $finish;
  end
endmodule